// File: doc/BRIEF.md
# Flag-Producing Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit for a small load/store integer core. Two operands and a 4-bit operation code enter; one result word and four condition flags leave in the same cycle. The operation code comes from the core's decoder, so register-register and immediate instructions of the same kind reach this block as the same code on the same two operand inputs.

One adder serves the add, subtract and compare operations. Subtract and compare share its inverted-operand path. The shift amount arrives on operand A, and only its low five bits are used. The value to shift arrives on operand B. The core uses the flags to resolve branches and set-on-less-than results: zero for equality, carry/borrow for unsigned ordering, a sign-compare flag for signed ordering that stays correct under overflow, and an overflow flag for the signed arithmetic codes only.

Top module: `flag_alu`

## Requirements
- R1: For code 0 (signed add) and code 1 (unsigned add), the result is A+B modulo 2^32, and the carry flag is the carry out of bit 31.
- R2: For code 2 (signed subtract) and code 3 (unsigned subtract), the result is A-B modulo 2^32. For codes 2, 3, 8 and 9, the carry flag is 1 exactly when A < B as unsigned numbers.
- R3: The overflow flag is 1 only for codes 0 and 2, and only when the true signed sum or difference does not fit in 32 bits. It is 0 for every other code.
- R4: The zero flag is 1 exactly when the result is all zeros. Under code 3 it therefore reports A == B.
- R5: For codes 2, 3, 8 and 9, the sign-compare flag is 1 exactly when A < B as signed numbers, including when the subtraction overflows. It is 0 for all other codes.
- R6: Code 8 (signed set-less-than) gives a result of 1 if A < B as signed numbers and 0 otherwise.
- R7: Code 9 (unsigned set-less-than) gives a result of 1 if A < B as unsigned numbers and 0 otherwise.
- R8: Code 4 gives A AND B, code 5 gives A OR B, code 6 gives A XOR B, and code 7 gives NOT(A OR B).
- R9: Code 10 shifts B left and code 11 shifts B right logically, each by A[4:0] places with zero fill. Bits 31:5 of A have no effect.
- R10: Code 12 shifts B right by A[4:0] places and fills the vacated upper bits with B[31].
- R11: Code 13 gives B[15:0] in result bits 31:16 and zeros in bits 15:0.
- R12: Codes 14 and 15 give a zero result, with the zero flag at 1 and the other three flags at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 4 | Operation code (see R1 to R12) |
| opnd_a | input | 32 | First operand; shift amount for codes 10 to 12 |
| opnd_b | input | 32 | Second operand; shifted value for codes 10 to 12, source half for code 13 |
| result | output | 32 | Result word |
| zero_flag | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Carry out for adds, borrow for subtract and compare |
| sign_flag | output | 1 | Signed A < B for subtract and compare codes |
| ovf_flag | output | 1 | Signed overflow for codes 0 and 2 |

## Verification
The block holds no state, so any fault in its internal selection or carry logic shows at the ports in the same cycle as the stimulus. The bench drives one vector per clock and compares all five outputs half a period later. A mis-gated flag therefore appears on the first vector whose code should have cleared it. A wrong shift stage appears only for amounts that set that stage's bit, so the vectors sweep shift amounts with different bit patterns and include sign-boundary operands for the overflow and signed-compare paths.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADDS = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUBS = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLTS = 4'd8,
        OP_SLTU = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_LUI  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_sel_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_mode_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow,
    output logic             signed_lt
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    assign b_eff = subtract ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
    assign sum       = wide[WIDTH-1:0];
    assign carry_out = wide[WIDTH];
    // Same-sign inputs producing an opposite-sign result
    assign overflow  = (a[WIDTH-1] == b_eff[WIDTH-1]) && (wide[WIDTH-1] != a[WIDTH-1]);
    // Sign of difference corrected by overflow
    assign signed_lt = wide[WIDTH-1] ^ overflow;
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_sel_e       sel,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [$clog2(WIDTH)-1:0] amount,
    input  logic [WIDTH-1:0]         value,
    input  shift_mode_e              mode,
    output logic [WIDTH-1:0]         y
);
    localparam int STAGES = $clog2(WIDTH);

    logic             left;
    logic             fill;
    logic [WIDTH-1:0] value_rev;
    logic [WIDTH-1:0] stage_in;
    logic [WIDTH-1:0] stage [STAGES+1];
    logic [WIDTH-1:0] out_rev;

    assign left = (mode == SH_LEFT);
    assign fill = (mode == SH_RARI) & value[WIDTH-1];

    // Left shift reuses the right shifter on bit-reversed data
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign value_rev[i] = value[WIDTH-1-i];
        assign out_rev[i]   = stage[STAGES][WIDTH-1-i];
    end

    assign stage_in = left ? value_rev : value;
    assign stage[0] = stage_in;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int DIST = 1 << s;
        assign stage[s+1] = amount[s]
            ? {{DIST{fill}}, stage[s][WIDTH-1:DIST]}
            : stage[s];
    end

    assign y = left ? out_rev : stage[STAGES];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       alu_op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             carry_flag,
    output logic             sign_flag,
    output logic             ovf_flag
);
    localparam int SHW  = $clog2(WIDTH);
    localparam int HALF = WIDTH / 2;

    alu_op_e     op;
    logic        sub_grp;
    logic        add_grp;
    logic        signed_arith;
    logic [WIDTH-1:0] arith_y;
    logic        arith_c;
    logic        arith_v;
    logic        arith_lt;
    logic_sel_e  lsel;
    logic [WIDTH-1:0] logic_y;
    shift_mode_e smode;
    logic [WIDTH-1:0] shift_y;

    assign op = alu_op_e'(alu_op);

    assign add_grp      = (op == OP_ADDS) || (op == OP_ADDU);
    assign sub_grp      = (op == OP_SUBS) || (op == OP_SUBU)
                       || (op == OP_SLTS) || (op == OP_SLTU);
    assign signed_arith = (op == OP_ADDS) || (op == OP_SUBS);

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a         (opnd_a),
        .b         (opnd_b),
        .subtract  (sub_grp),
        .sum       (arith_y),
        .carry_out (arith_c),
        .overflow  (arith_v),
        .signed_lt (arith_lt)
    );

    assign lsel = logic_sel_e'(alu_op[1:0]);

    alu_bitwise #(.WIDTH(WIDTH)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (lsel),
        .y   (logic_y)
    );

    always_comb begin
        unique case (op)
            OP_SRL:  smode = SH_RLOG;
            OP_SRA:  smode = SH_RARI;
            default: smode = SH_LEFT;
        endcase
    end

    alu_shift #(.WIDTH(WIDTH)) u_shift (
        .amount (opnd_a[SHW-1:0]),
        .value  (opnd_b),
        .mode   (smode),
        .y      (shift_y)
    );

    always_comb begin
        unique case (op)
            OP_ADDS, OP_ADDU, OP_SUBS, OP_SUBU:
                result = arith_y;
            OP_AND, OP_OR, OP_XOR, OP_NOR:
                result = logic_y;
            OP_SLTS:
                result = {{(WIDTH-1){1'b0}}, arith_lt};
            OP_SLTU:
                result = {{(WIDTH-1){1'b0}}, ~arith_c};
            OP_SLL, OP_SRL, OP_SRA:
                result = shift_y;
            OP_LUI:
                result = {opnd_b[HALF-1:0], {HALF{1'b0}}};
            default:
                result = '0;
        endcase
    end

    always_comb begin
        carry_flag = 1'b0;
        if (add_grp)      carry_flag = arith_c;
        else if (sub_grp) carry_flag = ~arith_c;
    end

    assign sign_flag = sub_grp & arith_lt;
    assign ovf_flag  = signed_arith & arith_v;
    assign zero_flag = (result == '0);
endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [3:0]       alu_op,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             zero_flag,
    input logic             carry_flag,
    input logic             sign_flag,
    input logic             ovf_flag
);
    localparam int HALF = WIDTH / 2;

    always_comb begin
        if (!(alu_op == OP_ADDS || alu_op == OP_SUBS)) begin
            assert_no_overflow_R3: assert (!ovf_flag)
                else $error("overflow flag set for code %0d", alu_op);
        end
        if (alu_op == OP_SUBU) begin
            assert_subu_equal_R4: assert (zero_flag == (opnd_a == opnd_b))
                else $error("zero flag disagrees with operand equality");
        end
        if (alu_op == OP_SLTU) begin
            assert_sltu_borrow_R7: assert (result == {{(WIDTH-1){1'b0}}, carry_flag})
                else $error("unsigned compare result differs from borrow");
        end
        if (alu_op == OP_SLTS) begin
            assert_slts_sign_R6: assert (result == {{(WIDTH-1){1'b0}}, sign_flag})
                else $error("signed compare result differs from sign flag");
        end
        if (alu_op == OP_LUI) begin
            assert_lui_place_R11: assert (result[HALF-1:0] == '0
                                          && result[WIDTH-1:HALF] == opnd_b[HALF-1:0])
                else $error("upper-load placement wrong");
        end
        if (alu_op == OP_SRA) begin
            assert_sra_fill_R10: assert (result[WIDTH-1] == opnd_b[WIDTH-1])
                else $error("arithmetic shift lost sign");
        end
        if (!(alu_op == OP_SUBS || alu_op == OP_SUBU
              || alu_op == OP_SLTS || alu_op == OP_SLTU)) begin
            assert_sign_gated_R5: assert (!sign_flag)
                else $error("sign flag set outside compare codes");
        end
    end
endmodule

bind flag_alu flag_alu_checker #(.WIDTH(WIDTH)) u_flag_alu_chk (
    .alu_op     (alu_op),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .result     (result),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag),
    .sign_flag  (sign_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  alu_op = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        zero_flag, carry_flag, sign_flag, ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flag_alu dut (
        .alu_op     (alu_op),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .result     (result),
        .zero_flag  (zero_flag),
        .carry_flag (carry_flag),
        .sign_flag  (sign_flag),
        .ovf_flag   (ovf_flag)
    );

    function automatic string res_tag(input logic [3:0] o);
        case (o)
            4'd0, 4'd1:              return "R1";
            4'd2, 4'd3:              return "R2";
            4'd4, 4'd5, 4'd6, 4'd7:  return "R8";
            4'd8:                    return "R6";
            4'd9:                    return "R7";
            4'd10, 4'd11:            return "R9";
            4'd12:                   return "R10";
            4'd13:                   return "R11";
            default:                 return "R12";
        endcase
    endfunction

    function automatic bit out_of_range(input longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         output logic [31:0] r, output bit z, output bit c,
                         output bit s, output bit v);
        longint sx, sy;
        logic [63:0] ux, uy;
        logic signed [31:0] sy32;
        int amt;
        sx = $signed(x);
        sy = $signed(y);
        ux = {32'd0, x};
        uy = {32'd0, y};
        sy32 = y;
        amt = int'(x[4:0]);
        c = 0; s = 0; v = 0; r = '0;
        case (o)
            4'd0, 4'd1: begin
                r = x + y;
                c = ((ux + uy) >> 32) != 0;
                if (o == 4'd0) v = out_of_range(sx + sy);
            end
            4'd2, 4'd3, 4'd8, 4'd9: begin
                c = (x < y);
                s = (sx < sy);
                if (o == 4'd2) v = out_of_range(sx - sy);
                if (o == 4'd8)      r = s ? 32'd1 : 32'd0;
                else if (o == 4'd9) r = c ? 32'd1 : 32'd0;
                else                r = x - y;
            end
            4'd4:  r = x & y;
            4'd5:  r = x | y;
            4'd6:  r = x ^ y;
            4'd7:  r = ~(x | y);
            4'd10: r = y << amt;
            4'd11: r = y >> amt;
            4'd12: r = sy32 >>> amt;
            4'd13: r = {y[15:0], 16'h0000};
            default: r = '0;
        endcase
        z = (r == 0);
    endtask

    task automatic chk1(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, what, alu_op, opnd_a, opnd_b, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] er;
        bit ez, ec, es, ev;
        @(posedge clk);
        alu_op <= o;
        opnd_a <= x;
        opnd_b <= y;
        @(negedge clk);
        model(o, x, y, er, ez, ec, es, ev);
        chk1(res_tag(o), "result", result, er);
        chk1("R4", "zero", {31'd0, zero_flag}, {31'd0, ez});
        chk1((o <= 4'd1) ? "R1" : "R2", "carry", {31'd0, carry_flag}, {31'd0, ec});
        chk1("R5", "sign", {31'd0, sign_flag}, {31'd0, es});
        chk1("R3", "overflow", {31'd0, ovf_flag}, {31'd0, ev});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero inputs under code 0 give a zero result (R1, R4)
        chk1("R1", "reset result", result, 32'd0);
        chk1("R4", "reset zero", {31'd0, zero_flag}, 32'd1);

        // R1 / R3: add carry and signed overflow
        apply(4'd0, 32'h7fffffff, 32'h00000001);
        apply(4'd0, 32'h80000000, 32'h80000000);
        apply(4'd1, 32'hffffffff, 32'h00000001);
        apply(4'd1, 32'h7fffffff, 32'h00000001);
        // R2 / R3 / R5: subtract borrow, overflow, signed compare under overflow
        apply(4'd2, 32'h80000000, 32'h00000001);
        apply(4'd2, 32'h7fffffff, 32'hffffffff);
        apply(4'd3, 32'h00000001, 32'h00000002);
        apply(4'd3, 32'h12345678, 32'h12345678);
        // R6 / R7: compares at sign boundaries
        apply(4'd8, 32'h80000000, 32'h7fffffff);
        apply(4'd8, 32'h7fffffff, 32'h80000000);
        apply(4'd9, 32'h80000000, 32'h7fffffff);
        apply(4'd9, 32'h00000005, 32'h00000005);
        // R8: logic
        apply(4'd4, 32'hf0f0ff00, 32'h0ff0f0f0);
        apply(4'd5, 32'hf0f0ff00, 32'h0ff0f0f0);
        apply(4'd6, 32'hf0f0ff00, 32'h0ff0f0f0);
        apply(4'd7, 32'hf0f0ff00, 32'h0ff0f0f0);
        apply(4'd7, 32'hffffffff, 32'h00000000);
        // R9 / R10: shifts, upper amount bits ignored
        for (int k = 0; k < 32; k++) begin
            apply(4'd10, 32'hffffffe0 | k, 32'h8000_0001);
            apply(4'd11, 32'h12340000 | k, 32'h8000_0001);
            apply(4'd12, 32'h00000020 | k, 32'h8765_4321);
            apply(4'd12, k, 32'h4765_4321);
        end
        // R11: upper load
        apply(4'd13, 32'hdeadbeef, 32'hffff_a5c3);
        apply(4'd13, 32'h0, 32'h1234_0000);
        // R12: spare codes
        apply(4'd14, 32'hffffffff, 32'hffffffff);
        apply(4'd15, 32'h80000000, 32'h00000001);
        // Mixed vectors across every code
        for (int n = 0; n < 600; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (n % 7 == 0) rb = ra;
            if (n % 11 == 0) ra = ra ^ 32'h80000000;
            apply(4'(n % 16), ra, rb);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule